// File: doc/BRIEF.md
# Keyed-Sequence Software Watchdog

This block is a watchdog timer that software keeps alive by writing a two-byte key to a service register. While its enable input is high, an internal count advances on every clock. If the count reaches the programmed timeout limit before software completes the key, the block raises a reset request for a fixed number of clocks. The count then starts again from zero.

The key is a write of 0x55 followed later by a write of 0xAA to the service address. The first byte arms the sequence, and the second byte completes it and restarts the count. Any other byte written to the service address while the sequence is armed disarms it. Idle cycles and writes to other addresses do not disarm it.

Writes arrive on a valid/ready port. A write transfers on a clock edge where `wr_valid` and `wr_ready` are both high. The block lowers `wr_ready` only while a reset request is active. A writer must then hold its address and data stable until ready returns. No write is taken during that time.

Top module: `keyed_wdog`

## Requirements
- R1: While `wd_en` is low, the count is held at zero and the arm state is cleared, so `rst_req` never starts.
- R2: With `wd_en` high and no completed key, `rst_req` rises on the (L+1)th clock edge after the count restarted, where L is `tmo_limit`.
- R3: An accepted write of 0x55 to the service address arms the sequence. A later accepted write of 0xAA while armed restarts the count, so the next expiry is L+1 edges after that write.
- R4: An accepted write of any value other than 0xAA to the service address while armed disarms the sequence. A following 0x55 arms it again.
- R5: An accepted write of 0xAA to the service address while not armed has no effect on the count.
- R6: Idle cycles, and accepted writes to any address other than `SVC_ADDR` (default 0x0), do not disarm the sequence.
- R7: `rst_req` stays high for exactly 16 clock cycles (`RST_CYCLES`) each time it is raised.
- R8: When `rst_req` falls, the count is zero and the sequence is disarmed. The next expiry is L+1 edges after the falling edge.
- R9: `wr_ready` is low while `rst_req` is high, and a write offered in that time is not taken.
- R10: If a completing 0xAA write lands in the same cycle in which the count reaches L, the restart wins and no reset request starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_en | input | 1 | Watchdog run enable |
| tmo_limit | input | CNT_W (16) | Timeout count L, in clocks |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write can be taken |
| wr_addr | input | ADDR_W (4) | Register address of the write |
| wr_data | input | 8 | Write data byte |
| rst_req | output | 1 | Reset request pulse |

## Verification
The hardest case to reach from the ports is the one where the completing 0xAA arrives in the exact cycle in which the count equals the limit. A few cycles too early or too late, and the bench would only test an ordinary service or an ordinary expiry. The bench enables the watchdog with the count known to be zero and arms the key early with 0x55. It then counts edges so that the 0xAA transfer falls on edge L+1. It checks that no request starts, and that the next expiry comes L+1 edges after that write. Other tasks check the disarm, re-arm and foreign-address cases by whether the expiry edge moves or not.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;
endpackage

// File: rtl/keyed_wdog_seq.sv
module keyed_wdog_seq
  import keyed_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       armed,
  output logic       restart
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    if (!en || clr) begin
      state_d = SEQ_IDLE;
    end else if (svc_wr) begin
      if (svc_data == KEY_ARM) begin
        state_d = SEQ_ARMED;
      end else if (svc_data == KEY_FIRE && state_q == SEQ_ARMED) begin
        restart = 1'b1;
        state_d = SEQ_IDLE;
      end else begin
        state_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == SEQ_ARMED);

  // R3: an arming byte leaves the sequence armed on the next cycle
  assert_arm_on_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && svc_data == KEY_ARM && en && !clr) |=> armed);

  // R5: the completing byte does not arm an idle sequence
  assert_unarmed_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && svc_data == KEY_FIRE && !armed) |=> !armed);

  // R4: a wrong byte while armed disarms it
  assert_wrong_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && armed && svc_data != KEY_ARM && svc_data != KEY_FIRE) |=> !armed);
endmodule

// File: rtl/keyed_wdog_cnt.sv
module keyed_wdog_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = en && !hold && !restart && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (!en || hold || restart || expire) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R1: disabled watchdog holds a cleared count
  assert_off_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);

  // R3: a completed key restarts the count
  assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
endmodule

// File: rtl/keyed_wdog_pulse.sv
module keyed_wdog_pulse #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int PW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(RST_CYCLES - 1);

  logic [PW-1:0] pcnt_q;
  logic          act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pcnt_q <= '0;
    end else if (act_q) begin
      if (pcnt_q == LAST) begin
        act_q  <= 1'b0;
        pcnt_q <= '0;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end else if (fire) begin
      act_q  <= 1'b1;
      pcnt_q <= '0;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int          CNT_W      = 16,
  parameter int          ADDR_W     = 4,
  parameter int          RST_CYCLES = 16,
  parameter logic [3:0]  SVC_ADDR   = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_en,
  input  logic [CNT_W-1:0]  tmo_limit,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              rst_req
);
  localparam int HW = $clog2(RST_CYCLES + 1) + 1;

  logic             pulse_on;
  logic             svc_wr;
  logic             armed;
  logic             restart;
  logic             expire;
  logic [CNT_W-1:0] cnt;

  assign wr_ready = !pulse_on;
  assign svc_wr   = wr_valid && wr_ready && (wr_addr == ADDR_W'(SVC_ADDR));

  keyed_wdog_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (wd_en),
    .clr      (pulse_on),
    .svc_wr   (svc_wr),
    .svc_data (wr_data),
    .armed    (armed),
    .restart  (restart)
  );

  keyed_wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (wd_en),
    .hold    (pulse_on),
    .restart (restart),
    .limit   (tmo_limit),
    .cnt     (cnt),
    .expire  (expire)
  );

  keyed_wdog_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (expire),
    .active (pulse_on)
  );

  assign rst_req = pulse_on;

  // high-time counter used by the pulse length check
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (rst_req) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  // R7: each request lasts exactly RST_CYCLES clocks
  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> hi_cnt == HW'(RST_CYCLES));

  // R8: count and arm state are clean when the request ends
  assert_clean_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (cnt == '0 && !armed));

  // R2: a request starts only after the count met the limit
  assert_rise_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(cnt) == $past(tmo_limit) && $past(wd_en)));

  // R9: writes offered during the request change no arm state
  assert_no_take_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && wr_valid) |=> !armed);
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  localparam int L = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wd_en = 1'b0;
  logic [15:0] tmo_limit = 16'(L);
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = 4'h0;
  logic [7:0]  wr_data = 8'h00;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  keyed_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .tmo_limit(tmo_limit),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_req(rst_req)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_valid = 1'b0;
  endtask

  // count cleared, then enabled: edge 1 is the first counting edge
  task automatic fresh_start();
    wd_en = 1'b0; step(2); wd_en = 1'b1;
  endtask

  task automatic expect_rise_after(input int n, input string tag);
    step(n - 1); chk(rst_req, 1'b0, tag);
    step(1);     chk(rst_req, 1'b1, tag);
  endtask

  task automatic t_reset();
    chk(rst_req, 1'b0, "reset rst_req");
    chk(wr_ready, 1'b1, "reset wr_ready");
  endtask

  task automatic t_expire_and_pulse();
    fresh_start();
    expect_rise_after(L + 1, "R2 expiry edge");
    chk(wr_ready, 1'b0, "R9 ready low in pulse");
    wr_valid = 1'b1; wr_addr = 4'h0; wr_data = 8'h55;
    step(15); chk(rst_req, 1'b1, "R7 pulse still high");
    step(1);  chk(rst_req, 1'b0, "R7 pulse ended");
    wr_valid = 1'b0;
    chk(wr_ready, 1'b1, "R9 ready back");
    // R8: next expiry L+1 after fall; R9: the 0x55 during the pulse was not taken
    wr(4'h0, 8'hAA);
    expect_rise_after(L, "R8 R9 re-expiry after fall");
    step(16);
  endtask

  task automatic t_service();
    fresh_start();
    step(10); wr(4'h0, 8'h55); step(3); wr(4'h0, 8'hAA);
    expect_rise_after(L + 1, "R3 restart by key");
    step(16);
  endtask

  task automatic t_unarmed_fire();
    fresh_start();
    step(5); wr(4'h0, 8'hAA);
    expect_rise_after(L + 1 - 6, "R5 lone 0xAA ignored");
    step(16);
  endtask

  task automatic t_disarm_rearm();
    fresh_start();
    wr(4'h0, 8'h55); wr(4'h0, 8'h12); wr(4'h0, 8'hAA);
    expect_rise_after(L + 1 - 3, "R4 wrong byte disarms");
    step(16);
    fresh_start();
    wr(4'h0, 8'h55); wr(4'h0, 8'h12); wr(4'h0, 8'h55); step(2); wr(4'h0, 8'hAA);
    expect_rise_after(L + 1, "R4 re-arm works");
    step(16);
  endtask

  task automatic t_gaps_foreign();
    fresh_start();
    wr(4'h0, 8'h55); step(4); wr(4'h3, 8'h00); wr(4'h7, 8'h12); step(2);
    wr(4'h0, 8'hAA);
    expect_rise_after(L + 1, "R6 gaps and other addr");
    step(16);
    // a foreign-address 0xAA must not complete the key
    fresh_start();
    wr(4'h0, 8'h55); wr(4'h5, 8'hAA);
    expect_rise_after(L + 1 - 2, "R6 foreign 0xAA no restart");
    step(16);
  endtask

  task automatic t_disabled();
    wd_en = 1'b0;
    step(1);
    for (int i = 0; i < 3; i++) begin
      step(L);
      chk(rst_req, 1'b0, "R1 disabled no request");
    end
    wd_en = 1'b1; wr(4'h0, 8'h55); wd_en = 1'b0; step(1); wd_en = 1'b1;
    wr(4'h0, 8'hAA);
    expect_rise_after(L, "R1 disable clears arm");
    step(16);
  endtask

  task automatic t_race();
    fresh_start();
    wr(4'h0, 8'h55);
    step(L - 1);
    wr(4'h0, 8'hAA);
    chk(rst_req, 1'b0, "R10 restart beats expiry");
    expect_rise_after(L + 1, "R10 next expiry");
    step(16);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_expire_and_pulse();
    t_service();
    t_unarmed_fire();
    t_disarm_rearm();
    t_gaps_foreign();
    t_disabled();
    t_race();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule